// File: doc/BRIEF.md
# Segmented Transmit Pulse Shaper

This block produces the digital amplitude sequence for each line pulse in a bipolar transmitter. Eight programmable segment words set the pulse shape, so overshoot, main amplitude and undershoot can be tuned for a given cable length. A register write port loads the words. Each bit period is marked by a one-cycle strobe on a clock that runs at eight times the bit rate. Together with that strobe, the line encoder supplies a mark flag and a polarity flag.

For every bit, the shaper puts out eight sign-magnitude codes in sequence, one per fast-clock cycle, for an external DAC. A space gives a flat zero. A negative mark is the mirror image of a positive mark. When programmable shaping is disabled (any mode other than the one that uses it), a fixed built-in shape is sent. Writes never disturb a pulse already in flight: each bit works from a snapshot taken when its strobe arrives.

Top module: `tx_pulse_shaper`

## Requirements
- R1: After reset all eight segment words are 0 and segOut is 7'h00. With these defaults, a mark sent with shapeEn=1 gives 7'h00 on all eight segment cycles.
- R2: A write with wrEn=1 and wrAddr in 0x8..0xF loads wrData into segment (wrAddr-7), so 0x8 is segment 1 and 0xF is segment 8. Writes to 0x0..0x7 change no segment.
- R3: After a clock edge where bitStrobe=1, segOut carries segments 1 to 8 on the next eight cycles, one segment per cycle. It then holds 7'h00 until the next strobe.
- R4: Segment words and segOut use the same 7-bit sign-magnitude format: bit 6 is the sign (1 = positive, 0 = negative) and bits 5:0 are the magnitude. For a positive mark, each segment is output unchanged.
- R5: For a mark with negPol=1, each non-zero segment is output with its sign bit inverted and its magnitude unchanged.
- R6: For a space (markIn=0 at the strobe), segOut is 7'h00 on all eight segment cycles, whatever the segment words hold.
- R7: A segment whose magnitude is 0 is always output as 7'h00, never as 7'h40.
- R8: A write at any cycle of a pulse, including the strobe edge itself, does not change that pulse. It takes effect from the next strobe.
- R9: With shapeEn=0 at the strobe, a mark uses the fixed shape instead of the segment words. Segments 1..4 have magnitude 40 and are positive for negPol=0, negative for negPol=1. Segments 5..8 are 7'h00.
- R10: A strobe that arrives before segment 8 has been output aborts the current pulse. Segment 1 of the new pulse appears on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at eight times the bit rate |
| rstN | input | 1 | Asynchronous reset, active low |
| bitStrobe | input | 1 | One-cycle pulse that starts a bit period |
| markIn | input | 1 | Bit is a mark (1) or a space (0), sampled with bitStrobe |
| negPol | input | 1 | Mark polarity, 1 = negative, sampled with bitStrobe |
| shapeEn | input | 1 | 1 selects the programmed shape, 0 the fixed shape, sampled with bitStrobe |
| wrEn | input | 1 | Register write enable |
| wrAddr | input | 4 | Register offset within the channel page |
| wrData | input | 7 | Segment word, bit 6 is the sign, bits 5:0 the magnitude |
| segOut | output | 7 | Sign-magnitude code for the current eighth of the bit |

## Verification
A wrong segment index, a stale snapshot or an inverted sign shows up on segOut in the first affected eighth of a bit: one cycle after the strobe, or one cycle after the bad state arises. A write that leaks into the snapshot only shows once the modified segment's slot comes round within the pulse, so the bench writes into slots that have not yet been output. A control that fails to go idle after segment 8 shows up as a non-zero code on the ninth cycle.

// File: rtl/pulse_shaper_pkg.sv
package pulse_shaper_pkg;
  localparam int SEG_COUNT = 8;
  localparam int IDX_W = $clog2(SEG_COUNT);

  // strobes and latched bit attributes from control to datapath
  typedef struct packed {
    logic             snap;     // take snapshot of segment words
    logic             active;   // a pulse is in progress
    logic [IDX_W-1:0] segIdx;   // current segment, 0 = first
    logic             mark;
    logic             negPol;
    logic             useProg;  // programmed shape selected
  } shaperCtl_t;
endpackage

// File: rtl/shaper_ctrl.sv
module shaper_ctrl
  import pulse_shaper_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitStrobe,
  input  logic       markIn,
  input  logic       negPol,
  input  logic       shapeEn,
  output shaperCtl_t ctl
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SEG_COUNT - 1);

  logic             activeQ;
  logic [IDX_W-1:0] idxQ;
  logic             markQ;
  logic             negQ;
  logic             progQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      idxQ    <= '0;
      markQ   <= 1'b0;
      negQ    <= 1'b0;
      progQ   <= 1'b0;
    end else if (bitStrobe) begin
      activeQ <= 1'b1;
      idxQ    <= '0;
      markQ   <= markIn;
      negQ    <= negPol;
      progQ   <= shapeEn;
    end else if (activeQ) begin
      if (idxQ == LAST_IDX) begin
        activeQ <= 1'b0;
      end else begin
        idxQ <= idxQ + 1'b1;
      end
    end
  end

  always_comb begin
    ctl.snap    = bitStrobe;
    ctl.active  = activeQ;
    ctl.segIdx  = idxQ;
    ctl.mark    = markQ;
    ctl.negPol  = negQ;
    ctl.useProg = progQ;
  end
endmodule

// File: rtl/shaper_datapath.sv
module shaper_datapath
  import pulse_shaper_pkg::*;
#(
  parameter int MAG_W     = 6,
  parameter int ADDR_W    = 4,
  parameter int SEG_BASE  = 8,
  parameter int DEF_AMP   = 40,
  parameter int DEF_WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [MAG_W:0]   wrData,
  input  shaperCtl_t       ctl,
  output logic [MAG_W:0]   segOut
);
  localparam int PAGE_W = ADDR_W - IDX_W;
  localparam logic [PAGE_W-1:0] BASE_PAGE = PAGE_W'(SEG_BASE >> IDX_W);

  logic [MAG_W:0] segReg  [SEG_COUNT];
  logic [MAG_W:0] shadow  [SEG_COUNT];
  logic [MAG_W:0] defWord [SEG_COUNT];

  logic             pageHit;
  logic [IDX_W-1:0] wrIdx;

  assign pageHit = wrEn && (wrAddr[ADDR_W-1:IDX_W] == BASE_PAGE);
  assign wrIdx   = wrAddr[IDX_W-1:0];

  for (genvar g = 0; g < SEG_COUNT; g++) begin : gSeg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        segReg[g] <= '0;
      end else if (pageHit && (wrIdx == IDX_W'(g))) begin
        segReg[g] <= wrData;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shadow[g] <= '0;
      end else if (ctl.snap) begin
        shadow[g] <= segReg[g];
      end
    end

    if (g < DEF_WIDTH) begin : gDefOn
      assign defWord[g] = {1'b1, MAG_W'(DEF_AMP)};
    end else begin : gDefOff
      assign defWord[g] = '0;
    end
  end

  logic [MAG_W:0]   word;
  logic [MAG_W-1:0] mag;

  always_comb begin
    word = ctl.useProg ? shadow[ctl.segIdx] : defWord[ctl.segIdx];
    mag  = word[MAG_W-1:0];
    if (!ctl.active || !ctl.mark || (mag == '0)) begin
      segOut = '0;
    end else begin
      segOut = {word[MAG_W] ^ ctl.negPol, mag};
    end
  end
endmodule

// File: rtl/tx_pulse_shaper.sv
module tx_pulse_shaper
  import pulse_shaper_pkg::*;
#(
  parameter int MAG_W     = 6,
  parameter int ADDR_W    = 4,
  parameter int SEG_BASE  = 8,
  parameter int DEF_AMP   = 40,
  parameter int DEF_WIDTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitStrobe,
  input  logic              markIn,
  input  logic              negPol,
  input  logic              shapeEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [MAG_W:0]    wrData,
  output logic [MAG_W:0]    segOut
);
  shaperCtl_t ctl;

  shaper_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .bitStrobe(bitStrobe),
    .markIn   (markIn),
    .negPol   (negPol),
    .shapeEn  (shapeEn),
    .ctl      (ctl)
  );

  shaper_datapath #(
    .MAG_W    (MAG_W),
    .ADDR_W   (ADDR_W),
    .SEG_BASE (SEG_BASE),
    .DEF_AMP  (DEF_AMP),
    .DEF_WIDTH(DEF_WIDTH)
  ) uDp (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (wrEn),
    .wrAddr(wrAddr),
    .wrData(wrData),
    .ctl   (ctl),
    .segOut(segOut)
  );
endmodule

// File: rtl/tx_pulse_shaper_chk.sv
module tx_pulse_shaper_chk
  import pulse_shaper_pkg::*;
#(
  parameter int MAG_W   = 6,
  parameter int DEF_AMP = 40
) (
  input logic           clk,
  input logic           rstN,
  input logic           bitStrobe,
  input logic           markIn,
  input logic           negPol,
  input logic           shapeEn,
  input logic [MAG_W:0] segOut
);
  localparam int CNT_W = $clog2(SEG_COUNT + 1);
  logic [CNT_W-1:0] sinceStrobe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceStrobe <= CNT_W'(SEG_COUNT);
    end else if (bitStrobe) begin
      sinceStrobe <= '0;
    end else if (sinceStrobe != CNT_W'(SEG_COUNT)) begin
      sinceStrobe <= sinceStrobe + 1'b1;
    end
  end

  // R1: output is zero when reset is released
  a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> segOut == '0);

  // R3: idle once eight segments have gone out
  a_r3_idle_after_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (sinceStrobe == CNT_W'(SEG_COUNT)) |-> segOut == '0);

  // R6: a space starts with a zero segment
  a_r6_space_zero: assert property (@(posedge clk) disable iff (!rstN)
    (bitStrobe && !markIn) |=> segOut == '0);

  // R7: a positive sign never comes with zero magnitude
  a_r7_no_pos_zero: assert property (@(posedge clk) disable iff (!rstN)
    segOut[MAG_W] |-> (segOut[MAG_W-1:0] != '0));

  // R9: fixed shape first segment
  a_r9_fixed_first: assert property (@(posedge clk) disable iff (!rstN)
    (bitStrobe && !shapeEn && markIn) |=> segOut == {!$past(negPol), MAG_W'(DEF_AMP)});
endmodule

bind tx_pulse_shaper tx_pulse_shaper_chk #(.MAG_W(MAG_W), .DEF_AMP(DEF_AMP)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .bitStrobe(bitStrobe),
  .markIn   (markIn),
  .negPol   (negPol),
  .shapeEn  (shapeEn),
  .segOut   (segOut)
);

// File: tb/sim_tx_pulse_shaper.sv
`timescale 1ns/1ps
module sim_tx_pulse_shaper;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitStrobe = 1'b0;
  logic       markIn = 1'b0;
  logic       negPol = 1'b0;
  logic       shapeEn = 1'b1;
  logic       wrEn = 1'b0;
  logic [3:0] wrAddr = '0;
  logic [6:0] wrData = '0;
  logic [6:0] segOut;

  int testCnt = 0;
  int failCnt = 0;
  bit done = 0;
  string curReq = "R1";

  always #5 clk = ~clk;

  tx_pulse_shaper u0 (
    .clk(clk), .rstN(rstN), .bitStrobe(bitStrobe), .markIn(markIn),
    .negPol(negPol), .shapeEn(shapeEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .segOut(segOut)
  );

  // behavioural reference model
  int         mPos;
  bit         mMark, mNeg, mEn;
  logic [6:0] mRegs [8];
  logic [6:0] mSnap [8];

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPos = 8; mMark = 0; mNeg = 0; mEn = 0;
      for (int i = 0; i < 8; i++) begin mRegs[i] = '0; mSnap[i] = '0; end
    end else begin
      if (bitStrobe) begin
        mSnap = mRegs;
        mPos = 0; mMark = markIn; mNeg = negPol; mEn = shapeEn;
      end else if (mPos < 8) begin
        mPos = mPos + 1;
      end
      if (wrEn && wrAddr >= 4'h8) mRegs[wrAddr - 4'h8] = wrData;
    end
  end

  function automatic logic [6:0] expectOut();
    logic [6:0] w;
    if (mPos >= 8 || !mMark) return 7'h00;
    if (mEn) w = mSnap[mPos];
    else     w = (mPos < 4) ? {1'b1, 6'd40} : 7'h00;
    if (w[5:0] == 6'd0) return 7'h00;
    return {w[6] ^ mNeg, w[5:0]};
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      logic [6:0] e;
      e = expectOut();
      testCnt++;
      if (segOut !== e) begin
        failCnt++;
        $display("FAIL %s: t=%0t segOut=%h expected=%h", curReq, $time, segOut, e);
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic writeSeg(logic [3:0] a, logic [6:0] d);
    wrEn = 1; wrAddr = a; wrData = d;
    tick();
    wrEn = 0;
  endtask

  task automatic strobe(bit m, bit n, bit en);
    bitStrobe = 1; markIn = m; negPol = n; shapeEn = en;
    tick();
    bitStrobe = 0;
  endtask

  task automatic fullBit(bit m, bit n, bit en);
    strobe(m, n, en);
    tick(7);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      failCnt++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr;
    tick(3);
    rstN = 1;
    tick(2);
    // R1: defaults give all zero
    curReq = "R1";
    fullBit(1, 0, 1);
    fullBit(1, 1, 1);
    tick(3);
    // R2: writes to the lower half are ignored
    curReq = "R2";
    for (int a = 0; a < 8; a++) writeSeg(4'(a), 7'h7F);
    fullBit(1, 0, 1);
    tick(2);
    writeSeg(4'h8, 7'h45);
    writeSeg(4'h9, 7'h7F);
    writeSeg(4'hA, 7'h60);
    writeSeg(4'hB, 7'h50);
    writeSeg(4'hC, 7'h40);
    writeSeg(4'hD, 7'h03);
    writeSeg(4'hE, 7'h01);
    writeSeg(4'hF, 7'h00);
    // R3 R4: ordered positive pulse then idle
    curReq = "R3";
    fullBit(1, 0, 1);
    tick(4);
    curReq = "R4";
    fullBit(1, 0, 1);
    // R5: mirror image
    curReq = "R5";
    fullBit(1, 1, 1);
    fullBit(1, 0, 1);
    fullBit(1, 1, 1);
    // R6: spaces
    curReq = "R6";
    fullBit(0, 0, 1);
    fullBit(0, 1, 1);
    // R7: segment 5 holds 0x40, zero magnitude
    curReq = "R7";
    fullBit(1, 1, 1);
    tick(2);
    // R8: write during pulse into a later slot, and on the strobe edge
    curReq = "R8";
    strobe(1, 0, 1);
    tick(2);
    writeSeg(4'hE, 7'h3A);
    tick(4);
    fullBit(1, 0, 1);
    bitStrobe = 1; markIn = 1; negPol = 0; shapeEn = 1;
    wrEn = 1; wrAddr = 4'h8; wrData = 7'h11;
    tick();
    bitStrobe = 0; wrEn = 0;
    tick(7);
    fullBit(1, 0, 1);
    // R9: fixed shape ignores segment words
    curReq = "R9";
    fullBit(1, 0, 0);
    fullBit(1, 1, 0);
    fullBit(0, 0, 0);
    tick(2);
    // R10: early strobe restarts
    curReq = "R10";
    strobe(1, 0, 1);
    tick(2);
    strobe(1, 1, 1);
    tick(4);
    strobe(1, 0, 0);
    tick(10);
    // mixed traffic
    curReq = "R3";
    lfsr = 8'hA5;
    for (int k = 0; k < 200; k++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (lfsr[6]) writeSeg({1'b1, lfsr[2:0]}, {lfsr[7], lfsr[5:0]});
      fullBit(lfsr[0], lfsr[1], lfsr[3] | lfsr[4]);
    end
    tick(10);
    done = 1;
    summary();
    $finish;
  end
endmodule